// File: doc/BRIEF.md
# Fractional Serial Clock Generator

This block derives a serial peripheral clock from a fast reference clock. It does not count to N. A phase accumulator adds a programmed increment on every reference cycle, where 2048 stands for full scale. Each carry out of the accumulator toggles the serial clock, so the increment sets the clock rate in fractional steps of the reference. A double-rate select doubles the effective increment. A wrap-reset option clears the accumulator on every carry, which trades the exact average rate for a fixed period.

Alongside the clock level, the block produces one-cycle launch and latch strobes for the shift logic. These mark the serial clock edges on which data leaves and data is sampled. The phase input picks which edge gets which strobe, and the polarity input sets the resting level.

When no transfer is active and the idle-gate option is set, the clock parks at its polarity level, the accumulator is cleared and no strobes appear. With the gate option clear, the clock keeps running between transfers but still produces no strobes.

Top module: `spiclk_gen`

## Requirements
- R1: While reset is asserted, and for the two reference cycles of reset synchronisation after it is released, `sclk_o` equals `cpol_i` and both strobes are 0.
- R2: On each enabled reference cycle the effective increment is added to an 11-bit accumulator (modulus 2048). A sum of 2048 or more is a carry, and a carry inverts `sclk_o` on the next cycle. An increment of 0 never toggles the clock.
- R3: The effective increment is clamped to 2048. At 2048 or above, the serial clock toggles on every reference cycle.
- R4: When `dbl_rate_i` is 1, the effective increment is twice `fcw_i`, and the clamp of R3 still applies.
- R5: When `wrap_rst_i` is 1, the accumulator is set to 0 on every carry instead of keeping the remainder of the sum minus 2048. For example, an increment of 768 then toggles the clock every 3 cycles.
- R6: `sclk_o` is the internal toggle state XOR `cpol_i`, and the toggle state is 0 whenever the generator is stopped.
- R7: A carry during an active transfer raises exactly one strobe for one cycle, in the cycle the new clock level appears. With `cpha_i`=1, a rising edge gives `launch_o` and a falling edge gives `latch_o`. With `cpha_i`=0, a rising edge gives `latch_o` and a falling edge gives `launch_o`.
- R8: With `gate_idle_i`=1 and `run_i`=0, from the next cycle the accumulator and toggle state are cleared, `sclk_o` equals `cpol_i`, and no strobes are produced.
- R9: With `gate_idle_i`=0 and `run_i`=0, the clock keeps toggling at the programmed rate, but no strobes are produced.
- R10: `launch_o` and `latch_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Transfer active (a slave select is asserted) |
| gate_idle_i | input | 1 | Stop the clock while no transfer is active |
| fcw_i | input | 16 | Frequency control increment, 2048 = full scale |
| wrap_rst_i | input | 1 | Clear the accumulator on each carry |
| dbl_rate_i | input | 1 | Double the effective increment |
| cpol_i | input | 1 | Clock polarity (idle level) |
| cpha_i | input | 1 | Clock phase: 1 = launch on rising edge |
| sclk_o | output | 1 | Serial clock level |
| launch_o | output | 1 | One-cycle strobe on the data launch edge |
| latch_o | output | 1 | One-cycle strobe on the data latch edge |

## Verification
The bench targets several corner cases:
- The full-scale clamp at 2048 and above, where a missing clamp would let the adder overflow and skip toggles.
- An increment of 0, which must leave the clock frozen.
- The wrap-reset mode, where keeping the remainder would shorten some half-periods.
- The doubled increment, where a missing shift would halve the rate.
- Gated and free-running idle, where a design that forgets to clear the accumulator would start the next transfer with a shortened first half-period, and one that leaks strobes would clock data outside a transfer.
- Polarity and phase swaps, where a wrong edge mapping would swap the launch and latch strobes.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;

  // Edge direction of one serial clock transition, as seen on the pin.
  typedef struct packed {
    logic rise;
    logic fall;
  } spiclk_edge_t;

  localparam spiclk_edge_t SPICLK_NO_EDGE = '{rise: 1'b0, fall: 1'b0};

endpackage

// File: rtl/spiclk_rst_sync.sv
module spiclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign sync_d[g] = 1'b1;
      end else begin : g_next
        assign sync_d[g] = sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/spiclk_phase_acc.sv
module spiclk_phase_acc #(
  parameter int ACC_W = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic [ACC_W:0] inc_i,
  input  logic           wrap_rst_i,
  output logic           carry_o
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W:0]   sum;

  // inc_i is at most 2**ACC_W, so a single carry per cycle is the maximum.
  assign sum     = {1'b0, acc_q} + inc_i;
  assign carry_o = sum[ACC_W];

  always_comb begin
    acc_d = sum[ACC_W-1:0];
    if (clr_i) begin
      acc_d = '0;
    end else if (carry_o && wrap_rst_i) begin
      acc_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

endmodule

// File: rtl/spiclk_edge_gen.sv
module spiclk_edge_gen
  import spiclk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic run_i,
  input  logic carry_i,
  input  logic cpol_i,
  input  logic cpha_i,
  output logic sclk_o,
  output logic launch_o,
  output logic latch_o
);

  logic         tog_q, tog_d;
  spiclk_edge_t edge_q, edge_d;
  logic         lvl_next;

  always_comb begin
    tog_d    = tog_q;
    edge_d   = SPICLK_NO_EDGE;
    lvl_next = 1'b0;
    if (!en_i) begin
      tog_d = 1'b0;
    end else if (carry_i) begin
      tog_d       = ~tog_q;
      lvl_next    = tog_d ^ cpol_i;
      edge_d.rise = run_i & lvl_next;
      edge_d.fall = run_i & ~lvl_next;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q  <= 1'b0;
      edge_q <= SPICLK_NO_EDGE;
    end else begin
      tog_q  <= tog_d;
      edge_q <= edge_d;
    end
  end

  assign sclk_o   = tog_q ^ cpol_i;
  assign launch_o = cpha_i ? edge_q.rise : edge_q.fall;
  assign latch_o  = cpha_i ? edge_q.fall : edge_q.rise;

endmodule

// File: rtl/spiclk_gen.sv
module spiclk_gen #(
  parameter int FCW_W       = 16,
  parameter int ACC_W       = 11,
  parameter int SYNC_STAGES = 2,
  parameter bit DBL_RATE_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             gate_idle_i,
  input  logic [FCW_W-1:0] fcw_i,
  input  logic             wrap_rst_i,
  input  logic             dbl_rate_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  output logic             sclk_o,
  output logic             launch_o,
  output logic             latch_o
);

  localparam logic [FCW_W:0] FULL_SCALE = (FCW_W+1)'(1) << ACC_W;

  logic             rst_sync_n;
  logic             en;
  logic             carry;
  logic [FCW_W:0]   inc_scaled;
  logic [ACC_W:0]   inc_eff;

  spiclk_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  generate
    if (DBL_RATE_EN) begin : g_dbl
      assign inc_scaled = dbl_rate_i ? {fcw_i, 1'b0} : {1'b0, fcw_i};
    end else begin : g_single
      logic unused_dbl;
      assign unused_dbl = dbl_rate_i;
      assign inc_scaled = {1'b0, fcw_i};
    end
  endgenerate

  always_comb begin
    if (inc_scaled >= FULL_SCALE) inc_eff = FULL_SCALE[ACC_W:0];
    else                          inc_eff = inc_scaled[ACC_W:0];
  end

  assign en = run_i | ~gate_idle_i;

  spiclk_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .clr_i      (~en),
    .inc_i      (inc_eff),
    .wrap_rst_i (wrap_rst_i),
    .carry_o    (carry)
  );

  spiclk_edge_gen u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .en_i     (en),
    .run_i    (run_i),
    .carry_i  (carry),
    .cpol_i   (cpol_i),
    .cpha_i   (cpha_i),
    .sclk_o   (sclk_o),
    .launch_o (launch_o),
    .latch_o  (latch_o)
  );

endmodule

// File: rtl/spiclk_gen_chk.sv
module spiclk_gen_chk #(
  parameter int FCW_W = 16,
  parameter int ACC_W = 11
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             run_i,
  input logic             gate_idle_i,
  input logic [FCW_W-1:0] fcw_i,
  input logic             cpol_i,
  input logic             cpha_i,
  input logic             sclk_o,
  input logic             launch_o,
  input logic             latch_o
);

  localparam logic [FCW_W-1:0] FULL = FCW_W'(1) << ACC_W;

  logic alive;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) alive <= 1'b0;
    else        alive <= 1'b1;
  end

  a_r10_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(launch_o && latch_o));

  a_r8_gated_idle: assert property (@(posedge clk_i) disable iff (!rst_n)
    (alive && !run_i && gate_idle_i) |=> (sclk_o == cpol_i && !launch_o && !latch_o));

  a_r9_no_strobe_outside_run: assert property (@(posedge clk_i) disable iff (!rst_n)
    (alive && $past(!run_i)) |-> (!launch_o && !latch_o));

  a_r3_full_scale_toggle: assert property (@(posedge clk_i) disable iff (!rst_n)
    (alive && $past(run_i && fcw_i >= FULL) && $stable(cpol_i)) |-> (sclk_o != $past(sclk_o)));

  a_r7_strobe_on_edge: assert property (@(posedge clk_i) disable iff (!rst_n)
    (alive && (launch_o || latch_o) && $stable(cpol_i)) |-> (sclk_o != $past(sclk_o)));

  a_r7_rising_mapping: assert property (@(posedge clk_i) disable iff (!rst_n)
    (alive && $stable(cpol_i) && ((launch_o && cpha_i) || (latch_o && !cpha_i))) |-> sclk_o);

endmodule

bind spiclk_gen spiclk_gen_chk #(.FCW_W(FCW_W), .ACC_W(ACC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_sync_n),
  .run_i       (run_i),
  .gate_idle_i (gate_idle_i),
  .fcw_i       (fcw_i),
  .cpol_i      (cpol_i),
  .cpha_i      (cpha_i),
  .sclk_o      (sclk_o),
  .launch_o    (launch_o),
  .latch_o     (latch_o)
);

// File: tb/sim_spiclk_gen.sv
module sim_spiclk_gen;

  localparam int CLK_PERIOD = 10;
  localparam int FULL = 2048;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        run, gate, wrap, dbl, cpol, cpha;
  logic [15:0] fcw;
  logic        sclk, launch, latch;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;
  string tag      = "R1";

  // Behavioural model state.
  int m_acc;
  bit m_tog, m_rise, m_fall, m_s1, m_s2;

  always #(CLK_PERIOD/2) clk = ~clk;

  spiclk_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run), .gate_idle_i(gate),
    .fcw_i(fcw), .wrap_rst_i(wrap), .dbl_rate_i(dbl), .cpol_i(cpol),
    .cpha_i(cpha), .sclk_o(sclk), .launch_o(launch), .latch_o(latch)
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 = 0; m_s2 = 0; m_acc = 0; m_tog = 0; m_rise = 0; m_fall = 0;
    end else begin
      if (!m_s2) begin
        m_acc = 0; m_tog = 0; m_rise = 0; m_fall = 0;
      end else if (!(run || !gate)) begin
        m_acc = 0; m_tog = 0; m_rise = 0; m_fall = 0;
      end else begin
        int inc, s;
        bit c;
        inc = dbl ? 2 * int'(fcw) : int'(fcw);
        if (inc > FULL) inc = FULL;
        s = m_acc + inc;
        c = (s >= FULL);
        m_acc  = c ? (wrap ? 0 : s - FULL) : s;
        if (c) m_tog = !m_tog;
        m_rise = c && run && (m_tog ^ cpol);
        m_fall = c && run && !(m_tog ^ cpol);
      end
      m_s2 = m_s1; m_s1 = 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit e_sclk, e_launch, e_latch;
      e_sclk   = m_tog ^ cpol;
      e_launch = cpha ? m_rise : m_fall;
      e_latch  = cpha ? m_fall : m_rise;
      n_checks++;
      if (sclk !== e_sclk || launch !== e_launch || latch !== e_latch) begin
        n_fail++;
        $display("FAIL %s t=%0t sclk/launch/latch actual=%b%b%b expected=%b%b%b",
                 tag, $time, sclk, launch, latch, e_sclk, e_launch, e_latch);
      end
      n_checks++;
      if (launch === 1'b1 && latch === 1'b1) begin
        n_fail++;
        $display("FAIL R10 both strobes high actual=11 expected=not both");
      end
    end
  end

  task automatic drive(input string t, input bit r, input bit g, input int f,
                       input bit w, input bit d, input bit p, input bit h, input int n);
    @(posedge clk); #2;
    tag = t; run = r; gate = g; fcw = 16'(f); wrap = w; dbl = d; cpol = p; cpha = h;
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    rst_ni = 1'b0; run = 1; gate = 1; fcw = 16'd300; wrap = 0; dbl = 0; cpol = 0; cpha = 0;
    repeat (5) @(posedge clk);
    #2 rst_ni = 1'b1;
    repeat (3) @(posedge clk);                      // R1: sync release window
    drive("R2", 1, 1, 300,   0, 0, 0, 0, 200);
    drive("R2", 1, 1, 0,     0, 0, 0, 0, 30);       // R2: zero increment freezes
    drive("R2", 1, 1, 1000,  0, 0, 0, 0, 100);
    drive("R3", 1, 1, 2048,  0, 0, 0, 0, 20);
    drive("R3", 1, 1, 65535, 0, 0, 0, 0, 20);
    drive("R4", 1, 1, 700,   0, 1, 0, 0, 100);
    drive("R4", 1, 1, 1500,  0, 1, 0, 0, 20);
    drive("R5", 1, 1, 768,   1, 0, 0, 0, 100);
    drive("R5", 1, 1, 3,     1, 0, 0, 0, 1500);
    drive("R6", 1, 1, 500,   0, 0, 1, 0, 100);
    drive("R7", 1, 1, 600,   0, 0, 0, 1, 100);
    drive("R7", 1, 1, 600,   0, 0, 1, 1, 100);
    drive("R8", 0, 1, 600,   0, 0, 1, 1, 30);
    drive("R8", 1, 1, 900,   0, 0, 0, 0, 20);
    drive("R8", 0, 1, 900,   0, 0, 0, 0, 30);
    drive("R9", 0, 0, 900,   0, 0, 0, 1, 100);
    drive("R9", 1, 0, 900,   0, 0, 0, 1, 50);
    drive("R10", 1, 1, 2048, 0, 1, 1, 0, 40);
    @(negedge clk); #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule